// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Interface

This block is the device-side logic of a one-time-programmable program store while the device is held in programming mode. An external programmer raises a high-voltage-present flag and holds the device reset pin low to enter the mode. It then drives three active-level strobes (chip enable `ce`, output enable `oe` and the active-low program strobe `pgm_n`), an address and a data byte. The block decodes the strobes into operating modes. It collects up to four address/data pairs into a page buffer, and commits either that page or a single byte when the program strobe returns high. For verification it returns the stored byte on a data bus whose drive enable it controls.

The storage is a register array that starts fully erased (every byte FFh) on the logic reset. A program operation can only clear bits, so repeating a program pulse with the same data leaves the contents unchanged. Only addresses up to a parameterized last address are programmable. The default instance is a scaled-down array of 512 bytes whose top programmable address is 1EFh; a full-size build sets the last address to EFFFh.

A finite-state machine sequences the work. Its states are OFF (programming mode absent), IDLE, LATCH (a latch combination is being held), PG_PULSE (program strobe low in page mode), BY_PULSE (program strobe low in byte mode) and PG_WRITE (draining the page buffer into the array). The transitions are:
- OFF→IDLE on mode entry, and any state→OFF on mode exit.
- IDLE→LATCH on a latch combination, and LATCH→IDLE when that combination ends.
- IDLE→PG_PULSE or IDLE→BY_PULSE when the program strobe falls.
- PG_PULSE→PG_WRITE on a valid rising edge of the program strobe, and PG_WRITE→IDLE after the last buffer slot.
- BY_PULSE→IDLE on a rising edge of the program strobe (with the write) or on an abort (without it).
- PG_PULSE→IDLE on an abort.

Top module: `otp_prog_if`

## Requirements
- R1: Programming mode exists only while `hv_on`=1 and `dev_rst_n`=0. Outside it no write happens, `dout_en`=0, and any buffered page entries are discarded.
- R2: Entering the combination `ce`=1, `oe`=0, `pgm_n`=1 from IDLE captures `addr`/`din` once into the next free page slot. Holding the combination does not capture again.
- R3: The page buffer holds 4 entries, filled in slot order 0 to 3. Latches arriving while it is full are ignored.
- R4: With `ce`=1 and `oe`=1, a low pulse on `pgm_n` commits every valid page entry on its rising edge, one slot per cycle over the following 4 cycles.
- R5: With `ce`=0 and `oe`=1, a low pulse on `pgm_n` writes the `din` byte to `addr`, sampled in the cycle in which `pgm_n` is seen high again.
- R6: With `ce`=0, `oe`=0 and `pgm_n`=1 in IDLE, `dout_en`=1 and `dout` equals the stored byte. An address above the last programmable address reads FFh.
- R7: `dout_en` is 0 whenever `oe`=1 or `ce`=1.
- R8: While `pgm_n` stays high, no strobe pattern writes the array.
- R9: A write to an address above LAST_ADDR (default 1EFh) leaves the array unchanged. LAST_ADDR itself is writable.
- R10: After reset every byte reads FFh, and a write stores old AND new, so bits only go from 1 to 0.
- R11: The page buffer is emptied after each commit. A commit with fewer than 4 entries writes only those entries, and the next latch goes into slot 0 again.
- R12: If `ce` or `oe` changes while `pgm_n` is low, the pulse is aborted and nothing is written when `pgm_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low logic reset; erases the array and empties the buffer |
| hv_on | input | 1 | Programming voltage present flag |
| dev_rst_n | input | 1 | Device reset pin; low together with `hv_on` selects programming mode |
| ce | input | 1 | Chip enable strobe |
| oe | input | 1 | Output enable strobe (high disables the data outputs) |
| pgm_n | input | 1 | Active-low program strobe |
| addr | input | ADDR_W (9) | Program address |
| din | input | 8 | Data byte to latch or write |
| dout | output | 8 | Data returned in verify mode (0 when not driven) |
| dout_en | output | 1 | Data bus drive enable; 0 means the bus is high-impedance |

## Verification
A slot counter that fails to clear after a commit shows up at the ports as a later page whose bytes never reach the array. That is visible at the first verify after the next commit, a few cycles later. A state machine stuck outside IDLE shows as `dout_en` staying 0 in verify mode, or as writes that never appear. A wrongly merged write shows as bits returning to 1 at the next read of that address. The bench keeps its own image of the array and its own copy of the pending page, sweeps every address, and compares each read against the image right after the operation that could have disturbed it.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_LATCH,
        ST_PG_PULSE,
        ST_BY_PULSE,
        ST_PG_WRITE
    } prog_state_t;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode (
    input  logic hv_on,
    input  logic dev_rst_n,
    input  logic ce,
    input  logic oe,
    input  logic pgm_n,
    output logic prog_on,
    output logic m_latch,
    output logic m_verify,
    output logic m_pg_low,
    output logic m_pg_high,
    output logic m_by_low,
    output logic m_by_high
);

    always_comb begin
        prog_on   = hv_on & ~dev_rst_n;
        m_latch   = prog_on &  ce & ~oe &  pgm_n;
        m_verify  = prog_on & ~ce & ~oe &  pgm_n;
        m_pg_low  = prog_on &  ce &  oe & ~pgm_n;
        m_pg_high = prog_on &  ce &  oe &  pgm_n;
        m_by_low  = prog_on & ~ce &  oe & ~pgm_n;
        m_by_high = prog_on & ~ce &  oe &  pgm_n;
    end

endmodule

// File: rtl/otp_page_buf.sv
module otp_page_buf #(
    parameter int ADDR_W = 9,
    parameter int PAGE_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [7:0]        push_data,
    input  logic [(PAGE_N > 1 ? $clog2(PAGE_N) : 1)-1:0] rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              full
);

    localparam int CNT_W = $clog2(PAGE_N + 1);

    logic [CNT_W-1:0]  fill;
    logic [ADDR_W-1:0] e_addr  [PAGE_N];
    logic [7:0]        e_data  [PAGE_N];
    logic [PAGE_N-1:0] e_valid;

    assign full = (fill == CNT_W'(PAGE_N));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (clr) begin
            fill <= '0;
        end else if (push && !full) begin
            fill <= fill + 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                e_valid[g] <= 1'b0;
                e_addr[g]  <= '0;
                e_data[g]  <= '0;
            end else if (clr) begin
                e_valid[g] <= 1'b0;
            end else if (push && !full && fill == CNT_W'(g)) begin
                e_valid[g] <= 1'b1;
                e_addr[g]  <= push_addr;
                e_data[g]  <= push_data;
            end
        end
    end

    always_comb begin
        rd_addr  = e_addr[rd_idx];
        rd_data  = e_data[rd_idx];
        rd_valid = e_valid[rd_idx];
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(PAGE_N)); // R3
    AST_FULL_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !clr) |=> (fill == CNT_W'(PAGE_N))); // R3
    AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(e_valid) == int'(fill)); // R3

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int ADDR_W    = 9,
    parameter int LAST_ADDR = 'h1EF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    import otp_prog_pkg::*;

    localparam int                DEPTH  = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

    logic [7:0] cells [DEPTH];
    logic       w_in_range;

    assign w_in_range = (waddr <= LAST_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= ERASED_BYTE;
            end
        end else if (we && w_in_range) begin
            cells[waddr] <= cells[waddr] & wdata;
        end
    end

    always_comb begin
        rdata = (raddr <= LAST_A) ? cells[raddr] : ERASED_BYTE;
    end

    AST_NO_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(raddr) |-> ((rdata & ~$past(rdata)) == 8'h00)); // R10

endmodule

// File: rtl/otp_prog_if.sv
module otp_prog_if #(
    parameter int ADDR_W    = 9,
    parameter int LAST_ADDR = 'h1EF,
    parameter int PAGE_N    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_on,
    input  logic              dev_rst_n,
    input  logic              ce,
    input  logic              oe,
    input  logic              pgm_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);

    import otp_prog_pkg::*;

    localparam int IDX_W = (PAGE_N > 1) ? $clog2(PAGE_N) : 1;

    prog_state_t       state, state_nx;
    logic [IDX_W-1:0]  wr_idx, wr_idx_nx;
    logic              prog_on, m_latch, m_verify;
    logic              m_pg_low, m_pg_high, m_by_low, m_by_high;
    logic              buf_clr, buf_push, buf_full, buf_valid;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0]        buf_data;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata, mem_rdata;
    logic              last_slot;

    otp_mode_decode u_dec (
        .hv_on     (hv_on),
        .dev_rst_n (dev_rst_n),
        .ce        (ce),
        .oe        (oe),
        .pgm_n     (pgm_n),
        .prog_on   (prog_on),
        .m_latch   (m_latch),
        .m_verify  (m_verify),
        .m_pg_low  (m_pg_low),
        .m_pg_high (m_pg_high),
        .m_by_low  (m_by_low),
        .m_by_high (m_by_high)
    );

    otp_page_buf #(.ADDR_W(ADDR_W), .PAGE_N(PAGE_N)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .push      (buf_push),
        .push_addr (addr),
        .push_data (din),
        .rd_idx    (wr_idx),
        .rd_addr   (buf_addr),
        .rd_data   (buf_data),
        .rd_valid  (buf_valid),
        .full      (buf_full)
    );

    otp_cell_array #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr),
        .rdata (mem_rdata)
    );

    assign last_slot = (wr_idx == IDX_W'(PAGE_N - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            wr_idx <= '0;
        end else begin
            state  <= state_nx;
            wr_idx <= wr_idx_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx  = state;
        wr_idx_nx = wr_idx;
        if (!prog_on) begin
            state_nx  = ST_OFF;
            wr_idx_nx = '0;
        end else begin
            unique case (state)
                ST_OFF: state_nx = ST_IDLE;
                ST_IDLE: begin
                    if (m_latch)       state_nx = ST_LATCH;
                    else if (m_pg_low) state_nx = ST_PG_PULSE;
                    else if (m_by_low) state_nx = ST_BY_PULSE;
                end
                ST_LATCH: begin
                    if (!m_latch) state_nx = ST_IDLE;
                end
                ST_PG_PULSE: begin
                    if (m_pg_high) begin
                        state_nx  = ST_PG_WRITE;
                        wr_idx_nx = '0;
                    end else if (!m_pg_low) begin
                        state_nx = ST_IDLE;
                    end
                end
                ST_BY_PULSE: begin
                    if (!m_by_low) state_nx = ST_IDLE;
                end
                ST_PG_WRITE: begin
                    if (last_slot) begin
                        state_nx  = ST_IDLE;
                        wr_idx_nx = '0;
                    end else begin
                        wr_idx_nx = wr_idx + 1'b1;
                    end
                end
                default: state_nx = ST_OFF;
            endcase
        end
    end

    // Output logic
    always_comb begin
        buf_push  = 1'b0;
        buf_clr   = !prog_on;
        mem_we    = 1'b0;
        mem_waddr = addr;
        mem_wdata = din;
        dout_en   = 1'b0;
        dout      = 8'h00;
        unique case (state)
            ST_IDLE: begin
                buf_push = m_latch;
                if (m_verify) begin
                    dout_en = 1'b1;
                    dout    = mem_rdata;
                end
            end
            ST_BY_PULSE: begin
                mem_we = m_by_high;
            end
            ST_PG_WRITE: begin
                mem_we    = prog_on & buf_valid;
                mem_waddr = buf_addr;
                mem_wdata = buf_data;
                buf_clr   = buf_clr | last_slot;
            end
            default: ;
        endcase
    end

    AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !mem_we); // R1
    AST_CE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ce |-> !dout_en); // R7
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !dout_en); // R7
    AST_WRITE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == ST_BY_PULSE || state == ST_PG_WRITE)); // R8
    AST_BYTE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BY_PULSE && m_by_high) |=> (state == ST_IDLE || state == ST_OFF)); // R5
    AST_PAGE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PG_WRITE && last_slot) |=> !buf_full); // R11
    AST_LATCH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH) |-> !buf_push); // R2

endmodule

// File: tb/otp_prog_if_bench.sv
module otp_prog_if_bench;

    localparam int AW   = 9;
    localparam int LAST = 'h1EF;
    localparam int PN   = 4;
    localparam int NW   = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          hv_on, dev_rst_n, ce, oe, pgm_n;
    logic [AW-1:0] addr;
    logic [7:0]    din;
    logic [7:0]    dout;
    logic          dout_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0]    img [NW];
    logic [AW-1:0] q_a [PN];
    logic [7:0]    q_d [PN];
    int            q_n = 0;

    always #10 clk = ~clk;

    otp_prog_if #(.ADDR_W(AW), .LAST_ADDR(LAST), .PAGE_N(PN)) u_otp_prog_if (
        .clk(clk), .rst_n(rst_n), .hv_on(hv_on), .dev_rst_n(dev_rst_n),
        .ce(ce), .oe(oe), .pgm_n(pgm_n), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input logic [8:0] got, input logic [8:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        ce = 1'b1; oe = 1'b1; pgm_n = 1'b1;
    endtask

    task automatic enter_mode();
        @(negedge clk);
        hv_on = 1'b1; dev_rst_n = 1'b0; ce = 1'b1; oe = 1'b1; pgm_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic leave_mode();
        @(negedge clk);
        hv_on = 1'b0;
        q_n = 0;
        @(negedge clk);
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        if (a <= LAST) img[a] = img[a] & d;
    endtask

    task automatic byte_write(input int a, input logic [7:0] d, input bit modelled);
        @(negedge clk);
        addr = AW'(a); din = d; ce = 1'b0; oe = 1'b1; pgm_n = 1'b0;
        @(negedge clk);
        pgm_n = 1'b1;
        @(negedge clk);
        ce = 1'b1;
        if (modelled) model_write(a, d);
    endtask

    task automatic latch(input int a, input logic [7:0] d);
        @(negedge clk);
        addr = AW'(a); din = d; ce = 1'b1; oe = 1'b0; pgm_n = 1'b1;
        @(negedge clk);
        oe = 1'b1;
        if (q_n < PN) begin
            q_a[q_n] = AW'(a); q_d[q_n] = d; q_n++;
        end
    endtask

    task automatic page_commit();
        @(negedge clk);
        ce = 1'b1; oe = 1'b1; pgm_n = 1'b0;
        @(negedge clk);
        pgm_n = 1'b1;
        repeat (PN + 2) @(negedge clk);
        for (int k = 0; k < q_n; k++) model_write(int'(q_a[k]), q_d[k]);
        q_n = 0;
    endtask

    task automatic verify(input int a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        addr = AW'(a); ce = 1'b0; oe = 1'b0; pgm_n = 1'b1;
        #2;
        e = (a <= LAST) ? img[a] : 8'hFF;
        check({dout_en, dout}, {1'b1, e}, tag);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) img[i] = 8'hFF;
        rst_n = 1'b0; hv_on = 1'b0; dev_rst_n = 1'b1;
        ce = 1'b1; oe = 1'b1; pgm_n = 1'b1; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({8'h0, dout_en}, 9'h0, "R1 reset bus released");

        // R1: strobes ignored outside programming mode
        hv_on = 1'b1; dev_rst_n = 1'b1;
        byte_write(5, 8'h00, 1'b0);
        @(negedge clk);
        addr = AW'(5); ce = 1'b0; oe = 1'b0; pgm_n = 1'b1;
        #2 check({8'h0, dout_en}, 9'h0, "R1 verify off-mode");
        hv_on = 1'b0; dev_rst_n = 1'b0;
        byte_write(6, 8'h00, 1'b0);
        enter_mode();

        // R10/R6: erased sweep over every address
        for (int a = 0; a < NW; a++) verify(a, "R10 erased sweep");

        // R5: byte writes with arithmetic patterns
        for (int i = 0; i < 32; i++) byte_write(i * 13 + 1, 8'((i * 37) ^ 8'h5A), 1'b1);
        for (int i = 0; i < 32; i++) verify(i * 13 + 1, "R5 byte write");

        // R10: clear-only merge
        byte_write(14, 8'hFF, 1'b1);
        verify(14, "R10 FF write no change");
        byte_write(14, 8'h0F, 1'b1);
        verify(14, "R10 AND merge");
        byte_write(27, 8'h3C, 1'b1);
        byte_write(27, 8'h3C, 1'b1);
        verify(27, "R10 repeated pulse");

        // R2/R3/R4: full page plus an ignored fifth latch
        go_idle();
        for (int k = 0; k < PN; k++) latch(100 + k, 8'(8'hA0 + k * 5));
        latch(200, 8'h00);
        page_commit();
        for (int k = 0; k < PN; k++) verify(100 + k, "R4 page commit");
        verify(200, "R3 fifth latch ignored");

        // R2: holding the latch combination captures only once
        go_idle();
        @(negedge clk);
        addr = AW'(210); din = 8'h11; ce = 1'b1; oe = 1'b0; pgm_n = 1'b1;
        repeat (3) @(negedge clk);
        addr = AW'(211); din = 8'h22;
        @(negedge clk);
        oe = 1'b1;
        q_a[0] = AW'(210); q_d[0] = 8'h11; q_n = 1;
        page_commit();
        verify(210, "R2 first capture");
        verify(211, "R2 held combination no recapture");

        // R11: partial commit, then buffer restarts at slot 0
        go_idle();
        latch(300, 8'h81);
        latch(301, 8'h42);
        page_commit();
        verify(300, "R11 partial slot0");
        verify(301, "R11 partial slot1");
        verify(302, "R11 untouched slot");
        go_idle();
        for (int k = 0; k < PN; k++) latch(310 + k, 8'(k));
        page_commit();
        go_idle();
        latch(320, 8'h5A);
        page_commit();
        verify(320, "R11 buffer cleared after commit");

        // R9: range limit
        byte_write(LAST + 1, 8'h00, 1'b1);
        byte_write(NW - 1, 8'h00, 1'b1);
        byte_write(LAST, 8'h12, 1'b1);
        verify(LAST + 1, "R9 above last ignored");
        verify(NW - 1, "R9 top address ignored");
        verify(LAST, "R9 last address written");
        go_idle();
        latch(LAST + 3, 8'h00);
        page_commit();
        verify(LAST + 3, "R9 page above last ignored");

        // R8: program strobe held high never writes
        @(negedge clk);
        addr = AW'(50); din = 8'h00; ce = 1'b0; oe = 1'b1; pgm_n = 1'b1;
        repeat (4) @(negedge clk);
        ce = 1'b1;
        repeat (4) @(negedge clk);
        verify(50, "R8 inhibit");

        // R7: outputs released with ce or oe high
        @(negedge clk);
        addr = AW'(1); ce = 1'b0; oe = 1'b1; pgm_n = 1'b1;
        #2 check({8'h0, dout_en}, 9'h0, "R7 oe high");
        @(negedge clk);
        ce = 1'b1; oe = 1'b0; pgm_n = 1'b0;
        #2 check({8'h0, dout_en}, 9'h0, "R7 ce high");
        go_idle();

        // R12: strobes change mid-pulse -> no write
        @(negedge clk);
        addr = AW'(41); din = 8'h00; ce = 1'b0; oe = 1'b1; pgm_n = 1'b0;
        @(negedge clk);
        oe = 1'b0;
        @(negedge clk);
        pgm_n = 1'b1;
        go_idle();
        verify(41, "R12 byte abort");
        go_idle();
        latch(60, 8'h00);
        @(negedge clk);
        pgm_n = 1'b0;
        @(negedge clk);
        ce = 1'b0;
        @(negedge clk);
        pgm_n = 1'b1;
        q_n = 0;
        go_idle();
        repeat (PN + 2) @(negedge clk);
        verify(60, "R12 page abort");

        // R1: leaving the mode discards the buffered page
        leave_mode();
        enter_mode();
        page_commit();
        verify(60, "R1 buffer discarded on exit");

        // R6: final spot reads
        verify(LAST + 7, "R6 out-of-range reads FF");
        verify(101, "R6 stored byte");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule